// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Bridge

This block sits between a word-addressed memory-mapped slave port and a shared serial shift engine. It turns each read or write on the memory port into an ordered list of serial items and hands them to the engine one at a time. An item is an opcode or address byte to send, a data byte to send or receive, or a run of idle dummy clocks. Reads become a read command: an opcode, an address, an optional dummy gap, and then one unbroken data phase for the whole burst. Writes become a write-enable command, a page-program command carrying the data, and a status-polling loop.

The read opcode, dummy count, write opcode, polling opcode, address length and the lane count of each phase are plain configuration inputs, so software can change them between transfers. Typical power-on values are read opcode 0x03 with 10 dummy clocks, write opcode 0x02 and polling opcode 0x05. A write keeps waitrequest high until the polled status byte shows that the flash has finished. Data bytes travel least-significant byte first within each 32-bit word. The flash byte address is the word address shifted left by two and is sent most-significant byte first.

Top module: `sflash_mm_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `mm_waitreq` is 1 and both `sq_valid` and `mm_rvalid` are 0.
- R2: A read issues one TX item carrying `cfg_rd_op` in lane mode `cfg_cmd_mode`. It then issues the byte address (word address shifted left by 2) as 3 TX bytes when `cfg_addr4`=0 or 4 TX bytes when `cfg_addr4`=1, most-significant byte first, in lane mode `cfg_rd_addr_mode`. Item kinds are 0 = TX, 1 = RX and 2 = dummy gap.
- R3: When `cfg_dummy` is nonzero, one gap item (kind 2) follows the address, with `sq_data` equal to the count and the lane mode `cfg_rd_data_mode`. When `cfg_dummy` is 0, no gap item is issued.
- R4: A read burst of N words issues exactly 4·N RX items in lane mode `cfg_rd_data_mode`. Only the final RX item has `sq_end`=1. Each group of 4 returned bytes gives one `mm_rvalid` pulse, with the first byte in bits 7:0.
- R5: A write first issues TX 0x06 in lane mode `cfg_cmd_mode` with `sq_end`=1. It then issues `cfg_wr_op` in `cfg_cmd_mode`, the address in `cfg_wr_addr_mode` (length as in R2), and the data bytes least-significant first in `cfg_wr_data_mode`. Only the last data byte has `sq_end`=1.
- R6: A data byte whose byte enable is 0 is sent as 0xFF.
- R7: After the data, the block issues TX `cfg_poll_op` followed by one RX item with `sq_end`=1, both in `cfg_cmd_mode`. It repeats this pair while bit 0 of the returned byte is 1. Waitrequest stays high until a returned byte has bit 0 equal to 0.
- R8: A write burst of N words forms one page-program command. Each word except the last is accepted as soon as its 4 bytes have been issued.
- R9: While `sq_valid` is 1 and `sq_ready` is 0, the item (`sq_kind`, `sq_mode`, `sq_data`, `sq_end`) stays unchanged and `sq_valid` stays 1.
- R10: Every acceptance lowers `mm_waitreq` for exactly one cycle: once per read command and once per written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_addr | input | ADDR_W | Word address |
| mm_read | input | 1 | Read request |
| mm_write | input | 1 | Write request |
| mm_wdata | input | 32 | Write data word |
| mm_be | input | 4 | Byte enables of the write word |
| mm_burst | input | BURST_W | Burst length in words, 1 to 64 |
| mm_waitreq | output | 1 | Low for the single cycle in which a request is accepted |
| mm_rdata | output | 32 | Read data word |
| mm_rvalid | output | 1 | One pulse per read word |
| cfg_rd_op | input | 8 | Read opcode |
| cfg_dummy | input | 5 | Dummy clock count for reads, 0 to 31 |
| cfg_wr_op | input | 8 | Page-program opcode |
| cfg_poll_op | input | 8 | Status-read opcode used while polling |
| cfg_addr4 | input | 1 | 0: 3 address bytes, 1: 4 address bytes |
| cfg_cmd_mode | input | 2 | Lane mode for opcodes and polling (0: 1 lane, 1: 2 lanes, 2: 4 lanes) |
| cfg_rd_addr_mode | input | 2 | Lane mode for read address |
| cfg_rd_data_mode | input | 2 | Lane mode for read data and dummy gap |
| cfg_wr_addr_mode | input | 2 | Lane mode for write address |
| cfg_wr_data_mode | input | 2 | Lane mode for write data |
| sq_valid | output | 1 | Serial item valid |
| sq_ready | input | 1 | Shift engine takes the item |
| sq_kind | output | 2 | 0 TX byte, 1 RX byte, 2 dummy gap |
| sq_mode | output | 2 | Lane mode of the item |
| sq_data | output | 8 | TX byte or dummy count |
| sq_end | output | 1 | Release chip select after this item |
| sr_valid | input | 1 | Received byte strobe |
| sr_data | input | 8 | Received byte |

## Verification
The assertions assume that the shift engine returns exactly one `sr_valid` byte for each accepted RX item, and only after that item has been accepted. They also assume that the master keeps a request and its data steady while waitrequest is high, and that the burst count lies between 1 and 64. The bench engine model answers each RX item two cycles after acceptance and takes its answers from a queue filled per scenario. It stalls `sq_ready` on every third cycle so that holding an item under back-pressure is exercised. The master tasks change their outputs only after an acceptance edge.

// File: rtl/sfmb_pkg.sv
package sfmb_pkg;
  localparam logic [1:0] K_TX  = 2'd0;
  localparam logic [1:0] K_RX  = 2'd1;
  localparam logic [1:0] K_GAP = 2'd2;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_CMD, S_ADDR, S_GAP, S_RDATA, S_RWAIT,
    S_WDATA, S_WACK, S_WLOAD, S_POLLC, S_POLLR, S_PWAIT
  } sfmb_st_e;
endpackage

// File: rtl/sfmb_byte_pick.sv
module sfmb_byte_pick #(
  parameter int W = 32,
  localparam int NB = W / 8,
  localparam int SW = $clog2(NB)
) (
  input  logic [W-1:0]  word,
  input  logic [NB-1:0] be,
  input  logic [SW-1:0] sel,
  output logic [7:0]    byte_o
);
  logic [7:0] lane [NB];
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = be[g] ? word[g*8 +: 8] : 8'hFF;
  end
  assign byte_o = lane[sel];
endmodule

// File: rtl/sfmb_rd_gather.sv
module sfmb_rd_gather (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_en,
  input  logic [1:0]  cap_idx,
  input  logic [7:0]  cap_byte,
  output logic [31:0] word_o,
  output logic        valid_o
);
  logic [23:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      word_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_en) begin
        if (cap_idx == 2'd3) begin
          word_o <= {cap_byte, acc};
          valid_o <= 1'b1;
        end else begin
          acc[{cap_idx, 3'b000} +: 8] <= cap_byte;
        end
      end
    end
  end

  // R4
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(cap_en && cap_idx == 2'd3));
endmodule

// File: rtl/sfmb_ctrl.sv
module sfmb_ctrl import sfmb_pkg::*; #(
  parameter int ADDR_W  = 22,
  parameter int BURST_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  mm_addr,
  input  logic               mm_read,
  input  logic               mm_write,
  input  logic [31:0]        mm_wdata,
  input  logic [3:0]         mm_be,
  input  logic [BURST_W-1:0] mm_burst,
  output logic               mm_waitreq,
  input  logic [7:0]         cfg_rd_op,
  input  logic [4:0]         cfg_dummy,
  input  logic [7:0]         cfg_wr_op,
  input  logic [7:0]         cfg_poll_op,
  input  logic               cfg_addr4,
  input  logic [1:0]         cfg_cmd_mode,
  input  logic [1:0]         cfg_rd_addr_mode,
  input  logic [1:0]         cfg_rd_data_mode,
  input  logic [1:0]         cfg_wr_addr_mode,
  input  logic [1:0]         cfg_wr_data_mode,
  output logic               sq_valid,
  input  logic               sq_ready,
  output logic [1:0]         sq_kind,
  output logic [1:0]         sq_mode,
  output logic [7:0]         sq_data,
  output logic               sq_end,
  input  logic               sr_valid,
  input  logic               sr_busy,
  output logic               cap_en,
  output logic [1:0]         cap_idx
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  sfmb_st_e           st;
  logic               is_wr, ack;
  logic [BURST_W-1:0] left;
  logic [1:0]         idx;
  logic [31:0]        baddr, wword;
  logic [3:0]         wbe;
  logic [7:0]         wbyte, abyte;
  logic               want, go, last_word, last_byte;
  logic [1:0]         it_kind, it_mode;
  logic [7:0]         it_data;
  logic               it_end;

  sfmb_byte_pick #(.W(32)) u_pick (.word(wword), .be(wbe), .sel(idx), .byte_o(wbyte));

  assign abyte      = baddr[{idx, 3'b000} +: 8];
  assign last_word  = (left == ONE);
  assign last_byte  = (idx == 2'd3);
  assign mm_waitreq = ~ack;
  assign cap_en     = (st == S_RWAIT) && sr_valid;
  assign cap_idx    = idx;

  always_comb begin
    want = 1'b1; it_kind = K_TX; it_mode = cfg_cmd_mode; it_data = 8'h00; it_end = 1'b0;
    case (st)
      S_WREN:  begin it_data = OP_WREN; it_end = 1'b1; end
      S_CMD:   it_data = is_wr ? cfg_wr_op : cfg_rd_op;
      S_ADDR:  begin it_mode = is_wr ? cfg_wr_addr_mode : cfg_rd_addr_mode; it_data = abyte; end
      S_GAP:   begin it_kind = K_GAP; it_mode = cfg_rd_data_mode; it_data = {3'b000, cfg_dummy}; end
      S_RDATA: begin it_kind = K_RX; it_mode = cfg_rd_data_mode; it_end = last_word && last_byte; end
      S_WDATA: begin it_mode = cfg_wr_data_mode; it_data = wbyte; it_end = last_word && last_byte; end
      S_POLLC: it_data = cfg_poll_op;
      S_POLLR: begin it_kind = K_RX; it_end = 1'b1; end
      default: want = 1'b0;
    endcase
  end

  assign go = want && (!sq_valid || sq_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; is_wr <= 1'b0; ack <= 1'b0; left <= '0; idx <= '0;
      baddr <= '0; wword <= '0; wbe <= '0;
      sq_valid <= 1'b0; sq_kind <= K_TX; sq_mode <= '0; sq_data <= '0; sq_end <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (sq_valid && sq_ready) sq_valid <= 1'b0;
      if (go) begin
        sq_valid <= 1'b1; sq_kind <= it_kind; sq_mode <= it_mode;
        sq_data <= it_data; sq_end <= it_end;
      end
      case (st)
        S_IDLE: if (!ack) begin
          baddr <= 32'(mm_addr) << 2;
          left  <= mm_burst;
          if (mm_read) begin
            is_wr <= 1'b0; ack <= 1'b1; st <= S_CMD;
          end else if (mm_write) begin
            is_wr <= 1'b1; wword <= mm_wdata; wbe <= mm_be; st <= S_WREN;
          end
        end
        S_WREN: if (go) st <= S_CMD;
        S_CMD: if (go) begin
          idx <= cfg_addr4 ? 2'd3 : 2'd2;
          st  <= S_ADDR;
        end
        S_ADDR: if (go) begin
          if (idx == 2'd0) begin
            if (is_wr)                st <= S_WDATA;
            else if (cfg_dummy != '0) st <= S_GAP;
            else                      st <= S_RDATA;
          end else begin
            idx <= idx - 2'd1;
          end
        end
        S_GAP:   if (go) st <= S_RDATA;
        S_RDATA: if (go) st <= S_RWAIT;
        S_RWAIT: if (sr_valid) begin
          idx <= idx + 2'd1;
          if (last_byte) begin
            left <= left - ONE;
            st   <= last_word ? S_IDLE : S_RDATA;
          end else begin
            st <= S_RDATA;
          end
        end
        S_WDATA: if (go) begin
          idx <= idx + 2'd1;
          if (last_byte) begin
            if (last_word) st <= S_POLLC;
            else begin
              left <= left - ONE; ack <= 1'b1; st <= S_WACK;
            end
          end
        end
        S_WACK:  st <= S_WLOAD;
        S_WLOAD: if (mm_write) begin
          wword <= mm_wdata; wbe <= mm_be; st <= S_WDATA;
        end
        S_POLLC: if (go) st <= S_POLLR;
        S_POLLR: if (go) st <= S_PWAIT;
        S_PWAIT: if (sr_valid) begin
          if (sr_busy) st <= S_POLLC;
          else begin
            ack <= 1'b1; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_valid && !sq_ready) |=> (sq_valid && $stable(sq_kind) && $stable(sq_mode)
                                 && $stable(sq_data) && $stable(sq_end)));
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R7
  poll_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_PWAIT && sr_valid && sr_busy) |=> (!ack && st == S_POLLC));
  // R3
  gap_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_valid && sq_kind == K_GAP) |-> (sq_data != 8'h00 && !is_wr));
endmodule

// File: rtl/sflash_mm_bridge.sv
module sflash_mm_bridge #(
  parameter int ADDR_W  = 22,
  parameter int BURST_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  mm_addr,
  input  logic               mm_read,
  input  logic               mm_write,
  input  logic [31:0]        mm_wdata,
  input  logic [3:0]         mm_be,
  input  logic [BURST_W-1:0] mm_burst,
  output logic               mm_waitreq,
  output logic [31:0]        mm_rdata,
  output logic               mm_rvalid,
  input  logic [7:0]         cfg_rd_op,
  input  logic [4:0]         cfg_dummy,
  input  logic [7:0]         cfg_wr_op,
  input  logic [7:0]         cfg_poll_op,
  input  logic               cfg_addr4,
  input  logic [1:0]         cfg_cmd_mode,
  input  logic [1:0]         cfg_rd_addr_mode,
  input  logic [1:0]         cfg_rd_data_mode,
  input  logic [1:0]         cfg_wr_addr_mode,
  input  logic [1:0]         cfg_wr_data_mode,
  output logic               sq_valid,
  input  logic               sq_ready,
  output logic [1:0]         sq_kind,
  output logic [1:0]         sq_mode,
  output logic [7:0]         sq_data,
  output logic               sq_end,
  input  logic               sr_valid,
  input  logic [7:0]         sr_data
);
  logic       cap_en;
  logic [1:0] cap_idx;

  sfmb_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .mm_addr(mm_addr), .mm_read(mm_read), .mm_write(mm_write),
    .mm_wdata(mm_wdata), .mm_be(mm_be), .mm_burst(mm_burst), .mm_waitreq(mm_waitreq),
    .cfg_rd_op(cfg_rd_op), .cfg_dummy(cfg_dummy), .cfg_wr_op(cfg_wr_op),
    .cfg_poll_op(cfg_poll_op), .cfg_addr4(cfg_addr4), .cfg_cmd_mode(cfg_cmd_mode),
    .cfg_rd_addr_mode(cfg_rd_addr_mode), .cfg_rd_data_mode(cfg_rd_data_mode),
    .cfg_wr_addr_mode(cfg_wr_addr_mode), .cfg_wr_data_mode(cfg_wr_data_mode),
    .sq_valid(sq_valid), .sq_ready(sq_ready), .sq_kind(sq_kind), .sq_mode(sq_mode),
    .sq_data(sq_data), .sq_end(sq_end),
    .sr_valid(sr_valid), .sr_busy(sr_data[0]),
    .cap_en(cap_en), .cap_idx(cap_idx)
  );

  sfmb_rd_gather u_gather (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx), .cap_byte(sr_data),
    .word_o(mm_rdata), .valid_o(mm_rvalid)
  );
endmodule

// File: tb/sflash_mm_bridge_tb.sv
module sflash_mm_bridge_tb;
  localparam int AW = 22;
  localparam int BW = 7;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] mm_addr = '0;
  logic mm_read = 0, mm_write = 0;
  logic [31:0] mm_wdata = '0;
  logic [3:0] mm_be = 4'hF;
  logic [BW-1:0] mm_burst = BW'(1);
  logic mm_waitreq, mm_rvalid;
  logic [31:0] mm_rdata;
  logic [7:0] cfg_rd_op = 8'h03, cfg_wr_op = 8'h02, cfg_poll_op = 8'h05;
  logic [4:0] cfg_dummy = 5'd10;
  logic cfg_addr4 = 0;
  logic [1:0] cfg_cmd_mode = 0, cfg_rd_addr_mode = 0, cfg_rd_data_mode = 0;
  logic [1:0] cfg_wr_addr_mode = 0, cfg_wr_data_mode = 0;
  logic sq_valid, sq_end, sq_ready = 0, sr_valid = 0;
  logic [1:0] sq_kind, sq_mode;
  logic [7:0] sq_data, sr_data = '0;

  sflash_mm_bridge #(.ADDR_W(AW), .BURST_W(BW)) u_dut (.*);

  int checks = 0, failures = 0;
  logic [31:0] got [0:127];
  logic [31:0] expq [0:127];
  int got_n = 0, exp_n = 0;
  logic [7:0] rxq [0:63];
  int rx_rd = 0, rx_wait = 0, rdy_ctr = 0;
  logic [31:0] rdw [0:15];
  int rd_n = 0, low_n = 0, low_items = 0, hold_bad = 0;
  logic prev_hold = 0;
  logic [12:0] prev_item = '0;

  function automatic logic [31:0] pk(int k, int m, int d, int e);
    logic [31:0] r;
    r = {19'd0, k[1:0], m[1:0], (k == 1) ? 8'h00 : d[7:0], e[0]};
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic ex(int k, int m, int d, int e);
    expq[exp_n] = pk(k, m, d, e);
    exp_n++;
  endtask

  task automatic scen_reset();
    got_n = 0; exp_n = 0; rx_rd = 0; rd_n = 0; low_n = 0; low_items = 0;
  endtask

  task automatic cmp_items(string req);
    chk({req, " item count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) chk(req, got[i], expq[i]);
  endtask

  // engine model: ready pattern, item log, RX responses
  always @(negedge clk) begin
    if (rst) begin
      sq_ready = 0; sr_valid = 0; rx_wait = 0; prev_hold = 0;
    end else begin
      if (prev_hold && (!sq_valid || {sq_kind, sq_mode, sq_data, sq_end} != prev_item))
        hold_bad++;
      rdy_ctr++;
      sq_ready = (rdy_ctr % 3) != 1;
      if (sq_valid && sq_ready) begin
        got[got_n] = pk(int'(sq_kind), int'(sq_mode), int'(sq_data), int'(sq_end));
        got_n++;
        if (sq_kind == 2'd1) rx_wait = 3;
      end
      prev_hold = sq_valid && !sq_ready;
      prev_item = {sq_kind, sq_mode, sq_data, sq_end};
      sr_valid = 0;
      if (rx_wait > 0) begin
        rx_wait--;
        if (rx_wait == 0) begin
          sr_valid = 1; sr_data = rxq[rx_rd]; rx_rd++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mm_rvalid) begin rdw[rd_n] = mm_rdata; rd_n++; end
      if (!mm_waitreq) begin low_n++; low_items = got_n; end
    end
  end

  task automatic wait_accept();
    do @(negedge clk); while (mm_waitreq);
    @(posedge clk); #1;
  endtask

  task automatic do_read(logic [AW-1:0] a, int n);
    @(negedge clk);
    mm_addr = a; mm_burst = BW'(n); mm_read = 1;
    wait_accept();
    mm_read = 0;
    for (int c = 0; c < 3000 && rd_n < n; c++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  logic [31:0] wq [0:7];
  task automatic do_write(logic [AW-1:0] a, int n, logic [3:0] be);
    @(negedge clk);
    mm_addr = a; mm_burst = BW'(n); mm_write = 1;
    for (int i = 0; i < n; i++) begin
      mm_wdata = wq[i]; mm_be = be;
      wait_accept();
    end
    mm_write = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 waitreq in reset", 32'(mm_waitreq), 32'd1);
    chk("R1 sq_valid in reset", 32'(sq_valid), 32'd0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 waitreq after reset", 32'(mm_waitreq), 32'd1);
    chk("R1 sq_valid after reset", 32'(sq_valid), 32'd0);
    chk("R1 rvalid after reset", 32'(mm_rvalid), 32'd0);
  endtask

  // R2 R3 R4: single read, 3-byte address, dummy 10, single lanes
  task automatic t_read_single();
    scen_reset();
    rxq[0] = 8'h11; rxq[1] = 8'h22; rxq[2] = 8'h33; rxq[3] = 8'h44;
    ex(0, 0, 8'h03, 0); ex(0, 0, 8'h04, 0); ex(0, 0, 8'h8D, 0); ex(0, 0, 8'h14, 0);
    ex(2, 0, 10, 0);
    for (int i = 0; i < 4; i++) ex(1, 0, 0, i == 3);
    do_read(22'h012345, 1);
    cmp_items("R2/R3 single read items");
    chk("R4 read word count", 32'(rd_n), 32'd1);
    chk("R4 read word LSB first", rdw[0], 32'h44332211);
    chk("R10 read accept cycles", 32'(low_n), 32'd1);
  endtask

  // R2 R3 R4 R9: 3-word burst, 4-byte address, no dummy, mixed lanes
  task automatic t_read_burst();
    scen_reset();
    cfg_rd_op = 8'hEB; cfg_dummy = 0; cfg_addr4 = 1;
    cfg_cmd_mode = 1; cfg_rd_addr_mode = 2; cfg_rd_data_mode = 2;
    for (int i = 0; i < 12; i++) rxq[i] = 8'hA0 + 8'(i);
    ex(0, 1, 8'hEB, 0);
    ex(0, 2, 8'h00, 0); ex(0, 2, 8'h00, 0); ex(0, 2, 8'h04, 0); ex(0, 2, 8'h00, 0);
    for (int i = 0; i < 12; i++) ex(1, 2, 0, i == 11);
    do_read(22'h000100, 3);
    cmp_items("R2/R3/R4 burst read items");
    chk("R4 burst word count", 32'(rd_n), 32'd3);
    chk("R4 burst word0", rdw[0], 32'hA3A2A1A0);
    chk("R4 burst word2", rdw[2], 32'hABAAA9A8);
    chk("R10 burst read accept cycles", 32'(low_n), 32'd1);
    chk("R9 item held under stall", 32'(hold_bad), 32'd0);
  endtask

  // R5 R6 R7: single masked write, polled busy twice
  task automatic t_write_single();
    scen_reset();
    cfg_addr4 = 0; cfg_cmd_mode = 0;
    rxq[0] = 8'h01; rxq[1] = 8'h03; rxq[2] = 8'h00;
    ex(0, 0, 8'h06, 1); ex(0, 0, 8'h02, 0);
    ex(0, 0, 8'h00, 0); ex(0, 0, 8'h00, 0); ex(0, 0, 8'h40, 0);
    ex(0, 0, 8'hEF, 0); ex(0, 0, 8'hFF, 0); ex(0, 0, 8'hAD, 0); ex(0, 0, 8'hFF, 1);
    for (int p = 0; p < 3; p++) begin ex(0, 0, 8'h05, 0); ex(1, 0, 0, 1); end
    wq[0] = 32'hDEADBEEF;
    do_write(22'h000010, 1, 4'b0101);
    cmp_items("R5/R6/R7 masked write items");
    chk("R7 waitreq low cycles", 32'(low_n), 32'd1);
    chk("R7 accept after final poll", 32'(low_items), 32'(exp_n));
    chk("R5 no read data on write", 32'(rd_n), 32'd0);
  endtask

  // R5 R8 R10: 2-word burst write, 4-byte address, mixed lanes
  task automatic t_write_burst();
    scen_reset();
    cfg_addr4 = 1; cfg_cmd_mode = 1; cfg_wr_addr_mode = 0; cfg_wr_data_mode = 2;
    cfg_wr_op = 8'h32; cfg_poll_op = 8'h70;
    rxq[0] = 8'h80;
    ex(0, 1, 8'h06, 1); ex(0, 1, 8'h32, 0);
    ex(0, 0, 8'h00, 0); ex(0, 0, 8'hFF, 0); ex(0, 0, 8'hFF, 0); ex(0, 0, 8'hFC, 0);
    for (int i = 0; i < 8; i++) ex(0, 2, i, i == 7);
    ex(0, 1, 8'h70, 0); ex(1, 1, 0, 1);
    wq[0] = 32'h03020100; wq[1] = 32'h07060504;
    do_write(22'h3FFFFF, 2, 4'hF);
    cmp_items("R5/R8 burst write items");
    chk("R8 R10 one accept per word", 32'(low_n), 32'd2);
    chk("R9 item held under stall", 32'(hold_bad), 32'd0);
  endtask

  logic done = 0;
  initial begin
    t_reset();
    t_read_single();
    t_read_burst();
    t_write_single();
    t_write_burst();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule